// File: doc/BRIEF.md
# Write Precompensation Early/Late Detector

This block sits on the serial run-length-limited code stream just ahead of the write driver. For every one in the stream (a magnetic transition), it looks at the code cells around it and decides whether that transition will be pulled out of place by its neighbours. A transition that is crowded from one side only is marked. A mark on the LATE strobe means the external delay line should retard the transition, and a mark on the EARLY strobe means it should advance it. The strobes are aligned with a delayed copy of the code bit, so the delay line receives the bit and its shift request in the same cycle.

Crowding is judged against the closest spacing a (1,7) code allows: two code cells between ones. A neighbour exactly `SPACING` cells away counts as crowding. Wider gaps do not count. When a transition is crowded equally from both sides, the two pulls cancel and no shift is requested. A bypass control bit turns the marking off entirely, and the code path keeps running unchanged. The block generates no analog delays.

Top module: `precomp_detector`

## Requirements
- R1: While `rstN` is low, `codeOut`, `early` and `late` are all 0, whatever `codeIn` carries.
- R2: `codeOut` after clock edge n equals the `codeIn` value sampled at edge n-2. Samples from before the release of reset count as 0.
- R3: `late` after edge n is 1 when the bit sampled at edge n-2 is 1, the bit sampled at edge n-4 is 1, and the bit sampled at edge n is 0. In other words, the transition has a neighbour two cells earlier and none two cells later.
- R4: `early` after edge n is 1 when the bit sampled at edge n-2 is 1, the bit sampled at edge n is 1, and the bit sampled at edge n-4 is 0. In other words, the transition has a neighbour two cells later and none two cells earlier.
- R5: A one that has ones two cells away on both sides, or on neither side, raises neither strobe. Ones three or more cells away do not count as neighbours.
- R6: `early` and `late` are never 1 in the same cycle. Either strobe is 1 only in a cycle where `codeOut` is 1.
- R7: When `bypass` is 1 at edge n, both strobes are 0 after edge n. `bypass` has no effect on `codeOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code clock, one code cell per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| codeIn | input | 1 | Serial code bit, 1 marks a transition |
| bypass | input | 1 | 1 disables precompensation marking |
| codeOut | output | 1 | Code bit delayed to line up with the strobes |
| early | output | 1 | Request to advance the current transition |
| late | output | 1 | Request to retard the current transition |

## Verification
The bench sends every 8-bit word through the stream back to back. This reaches every neighbour arrangement, including 1T-spaced patterns that no valid code holds, and it exposes a detector that swaps the early and late sides or looks at the wrong window offset. Long random valid (1,7) streams follow. Their gaps span 2T to 8T, so a design that treated 3T neighbours as crowding, or flagged transitions crowded on both sides, would show spurious strobes. Bypass is switched on and off in the middle of the stream. A design that registered bypass one cycle too late, or let it disturb the code path, would miscompare at the switching cycles.

// File: rtl/precomp_pkg.sv
package precomp_pkg;
  // Shift requests produced by the decision logic for the centre cell.
  typedef struct packed {
    logic markEarly;
    logic markLate;
  } pcStrobeT;
endpackage

// File: rtl/precomp_ctrl.sv
module precomp_ctrl
  import precomp_pkg::*;
(
  input  logic     centerBit,
  input  logic     earlierNb,
  input  logic     laterNb,
  input  logic     bypass,
  output pcStrobeT strobe
);
  logic crowdedEarlyOnly;
  logic crowdedLateOnly;

  // A transition crowded from one side only is pushed away from that side.
  assign crowdedEarlyOnly = earlierNb & ~laterNb;
  assign crowdedLateOnly  = laterNb & ~earlierNb;

  always_comb begin
    strobe = '0;
    if (!bypass && centerBit) begin
      strobe.markLate  = crowdedEarlyOnly;
      strobe.markEarly = crowdedLateOnly;
    end
  end
endmodule

// File: rtl/precomp_datapath.sv
module precomp_datapath
  import precomp_pkg::*;
#(
  parameter int SPACING = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     codeIn,
  input  pcStrobeT strobe,
  output logic     centerBit,
  output logic     earlierNb,
  output logic     laterNb,
  output logic     codeOut,
  output logic     early,
  output logic     late
);
  localparam int HIST = 2 * SPACING;

  logic [HIST-1:0] hist;
  logic [HIST:0]   win;

  // win[0] is the newest cell; a larger index is older.
  assign win[0] = codeIn;

  generate
    for (genvar i = 0; i < HIST; i++) begin : g_tap
      assign win[i+1] = hist[i];
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) hist[0] <= 1'b0;
          else       hist[0] <= codeIn;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) hist[i] <= 1'b0;
          else       hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  assign centerBit = win[SPACING];
  assign earlierNb = win[HIST];
  assign laterNb   = win[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeOut <= 1'b0;
      early   <= 1'b0;
      late    <= 1'b0;
    end else begin
      codeOut <= centerBit;
      early   <= strobe.markEarly;
      late    <= strobe.markLate;
    end
  end

  // Cycles since reset, saturating; lets the delay check look back safely.
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN)           upCnt <= 2'd0;
    else if (upCnt != 3) upCnt <= upCnt + 2'd1;
  end

  // R2
  delay_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (codeOut == $past(codeIn, 3)));

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(early && late));

  // R6
  flag_needs_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (early || late) |-> codeOut);
endmodule

// File: rtl/precomp_detector.sv
module precomp_detector
  import precomp_pkg::*;
#(
  parameter int SPACING = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic codeIn,
  input  logic bypass,
  output logic codeOut,
  output logic early,
  output logic late
);
  pcStrobeT strobe;
  logic     centerBit;
  logic     earlierNb;
  logic     laterNb;

  precomp_ctrl u_ctrl (
    .centerBit (centerBit),
    .earlierNb (earlierNb),
    .laterNb   (laterNb),
    .bypass    (bypass),
    .strobe    (strobe)
  );

  precomp_datapath #(.SPACING(SPACING)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .codeIn    (codeIn),
    .strobe    (strobe),
    .centerBit (centerBit),
    .earlierNb (earlierNb),
    .laterNb   (laterNb),
    .codeOut   (codeOut),
    .early     (early),
    .late      (late)
  );

  // R7
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(bypass) |-> (!early && !late));
endmodule

// File: tb/precomp_detector_test.sv
module precomp_detector_test;
  localparam int NBITS = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic codeIn = 1'b0;
  logic bypass = 1'b0;
  logic codeOut, early, late;

  int vectors = 0;
  int errors = 0;
  int total = 0;
  bit finished = 1'b0;
  bit bits [NBITS];
  bit byp [NBITS];

  always #4 clk = ~clk;

  precomp_detector uut (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .bypass(bypass),
    .codeOut(codeOut), .early(early), .late(late)
  );

  function automatic bit at(int k);
    return (k < 0) ? 1'b0 : bits[k];
  endfunction

  task automatic check(string req, logic act, logic exp, int n);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step %0d: actual %b expected %b", req, n, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int n;
    // Phase 1: every 8-bit word, MSB first, no bypass.
    n = 0;
    for (int w = 0; w < 256; w++)
      for (int b = 7; b >= 0; b--) begin
        bits[n] = w[b];
        byp[n] = 1'b0;
        n++;
      end
    // Phase 2: valid (1,7) stream, gaps of 1..7 zeros, bypass in bursts.
    while (n < NBITS - 16) begin
      int gap = $urandom_range(7, 1);
      bits[n] = 1'b1; n++;
      for (int z = 0; z < gap; z++) begin bits[n] = 1'b0; n++; end
    end
    while (n < NBITS) begin bits[n] = 1'b0; n++; end
    for (int k = 2048; k < NBITS; k++) byp[k] = (((k / 97) % 3) == 1);
    total = NBITS;

    // R1: reset holds outputs low even with ones on the input.
    @(negedge clk); codeIn = 1'b1; bypass = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 codeOut", codeOut, 1'b0, -1);
    check("R1 early", early, 1'b0, -1);
    check("R1 late", late, 1'b0, -1);

    rstN = 1'b1;
    codeIn = bits[0]; bypass = byp[0];
    for (int k = 0; k < total; k++) begin
      bit c, e, l, expE, expL;
      @(negedge clk);
      c = at(k - 2);
      e = at(k);
      l = at(k - 4);
      expL = !byp[k] && c && l && !e;  // R3 / R5
      expE = !byp[k] && c && e && !l;  // R4 / R5
      check("R2 codeOut", codeOut, c, k);
      check(byp[k] ? "R7 late" : "R3 late", late, expL, k);
      check(byp[k] ? "R7 early" : "R4 early", early, expE, k);
      if (early && late) check("R6 exclusive", 1'b1, 1'b0, k);
      if (k + 1 < total) begin
        codeIn = bits[k+1];
        bypass = byp[k+1];
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule